// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the software-visible register file of a single DMA channel that serves one peripheral. It holds four 32-bit words: a control/status word, a running memory address, a byte count and a base/extra word. A host reaches them over a plain 32-bit register bus that accepts full-word accesses only. Reads come back combinationally in the same cycle. Writes land on the clock edge where the write strobe is high.

The control/status word carries three groups of fields. The first is interrupt state: a pending bit that follows the peripheral's request, and an enable bit that gates it onto the interrupt output. The second is peripheral control: a one-cycle reset pulse, a level enable and a transfer-direction bit. The third is fixed fields: a forced version code and bits that writes cannot change. The address word is advanced by the data engine, which reports each completed transfer together with its length. Writing the address word marks it as loaded in the control/status word.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control/status word reads 0xA0000000 and the address, count and base words read 0. The interrupt, reset-pulse, enable and direction outputs are low.
- R2: Only offset bits [3:2] select the word (0 control/status, 1 address, 2 count, 3 base). Higher offset bits are ignored, so offset 0x28 reaches the count word and 0x14 reaches the address word. Read data is the selected word in the same cycle.
- R3: A write whose byte enables are not all four set changes no register and no output.
- R4: Control/status bit 0 (pending) takes the level of the request input one clock after it is sampled. A write cannot change bit 0.
- R5: The interrupt output is high exactly while bit 0 (pending) and bit 4 (enable) are both set. Setting bit 4 while pending raises it, and clearing bit 4 lowers it.
- R6: A control/status write with bit 7 set drives the peripheral reset output high for exactly the one clock that follows the write. Bit 7 is stored as written.
- R7: In a control/status write without bit 7, a set bit 6 (drain) is stored as 0. A write of exactly 0 stores bit 6 as 1. When bit 7 is set, bit 6 is stored as written.
- R8: Bits under mask 0xFE000007 keep their earlier value on a control/status write. Bits 31 and 29 always read 1.
- R9: The peripheral enable output equals stored bit 9, and the direction output equals stored bit 8. Both change only through control/status writes.
- R10: A full-word write to the address word sets control/status bit 26 (loaded). Only reset clears it.
- R11: A transfer-done pulse adds the reported length to the address word, wrapping modulo 2^32. If the address word is written in the same cycle, the written value is stored and the length is dropped.
- R12: The count and base words store any full-word write and return it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | BUS_ADDR_W | Byte offset; only bits [3:2] are decoded |
| bus_be | input | 4 | Byte enables; a write needs all four set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word selected by bus_addr |
| irq_req_i | input | 1 | Interrupt request level from the peripheral |
| xfer_done_i | input | 1 | Data engine finished one transfer this cycle |
| xfer_len_i | input | LEN_W | Length in bytes of that transfer |
| dma_addr_o | output | 32 | Current address word, used by the data engine |
| irq_o | output | 1 | Gated interrupt output |
| periph_rst_o | output | 1 | One-cycle reset pulse to the peripheral |
| periph_en_o | output | 1 | Peripheral enable level (control/status bit 9) |
| mem_wr_dir_o | output | 1 | Direction select, 1 = write to memory (bit 8) |

## Verification
The control/status write path is driven with a set of fixed values to see whether each special case is decoded on its own. Those values are zero, drain alone, drain with reset, all ones and enable alone. Each one separates one rule from the others: the zero substitution, the drain clear, reset taking priority over drain, and the read-only mask with the forced version. The interrupt enable and the request are toggled in both orders, so a design that latches the output can be told apart from one that gates it. Address updates are applied alone, back to back, across the 2^32 wrap and together with a same-cycle write. A long random phase mixes every input, and a behavioural model is compared against every output on each clock.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] CSR_VERSION = 32'hA000_0000;
  localparam logic [DATA_W-1:0] CSR_RO_MASK = 32'hFE00_0007;
  localparam int PEND_BIT   = 0;
  localparam int IEN_BIT    = 4;
  localparam int DRAIN_BIT  = 6;
  localparam int PRST_BIT   = 7;
  localparam int DIR_BIT    = 8;
  localparam int EN_BIT     = 9;
  localparam int LOADED_BIT = 26;

  typedef enum logic [1:0] {
    SEL_CSR   = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_BASE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dma_csr_ctl.sv
`timescale 1ns/1ps
module dma_csr_ctl
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_csr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              loaded_set,
  input  logic              irq_req,
  output logic [DATA_W-1:0] csr_q,
  output logic              irq_o,
  output logic              periph_rst_o,
  output logic              periph_en_o,
  output logic              mem_wr_dir_o
);
  logic [DATA_W-1:0] csr_d;
  logic [DATA_W-1:0] wval;
  logic              pulse_d, pulse_q;

  always_comb begin
    wval    = wdata;
    pulse_d = 1'b0;
    if (wdata[PRST_BIT]) begin
      pulse_d = wr_csr;
    end else if (wdata[DRAIN_BIT]) begin
      wval[DRAIN_BIT] = 1'b0;
    end else if (wdata == '0) begin
      wval[DRAIN_BIT] = 1'b1;
    end
    csr_d = csr_q;
    if (wr_csr) begin
      csr_d = (csr_q & CSR_RO_MASK) | (wval & ~CSR_RO_MASK) | CSR_VERSION;
    end
    csr_d[PEND_BIT] = irq_req;
    if (loaded_set) begin
      csr_d[LOADED_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q   <= CSR_VERSION;
      pulse_q <= 1'b0;
    end else begin
      csr_q   <= csr_d;
      pulse_q <= pulse_d;
    end
  end

  assign irq_o        = csr_q[PEND_BIT] & csr_q[IEN_BIT];
  assign periph_rst_o = pulse_q;
  assign periph_en_o  = csr_q[EN_BIT];
  assign mem_wr_dir_o = csr_q[DIR_BIT];

  p_pend_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[PEND_BIT] |-> $past(irq_req));
  p_rst_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |-> $past(wr_csr && wdata[PRST_BIT]));
  p_version_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_q[31] && csr_q[29]));
  p_en_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_en_o) |-> $past(wr_csr && wdata[EN_BIT]));
  p_loaded_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csr_q[LOADED_BIT] |=> csr_q[LOADED_BIT]);
endmodule

// File: rtl/dma_addr_cnt.sv
`timescale 1ns/1ps
module dma_addr_cnt
  import dma_chan_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic [DATA_W-1:0] addr_q
);
  logic [DATA_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_en = wr | xfer_done;
    addr_d  = addr_q + DATA_W'(xfer_len);
    if (wr) addr_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  p_advance_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !wr) |=> (addr_q == $past(addr_q) + DATA_W'($past(xfer_len))));
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (addr_q == $past(wdata)));
endmodule

// File: rtl/dma_word_reg.sv
`timescale 1ns/1ps
module dma_word_reg
  import dma_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/dma_chan_regs.sv
`timescale 1ns/1ps
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int BUS_ADDR_W = 6,
  parameter int LEN_W      = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [3:0]            bus_be,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  irq_req_i,
  input  logic                  xfer_done_i,
  input  logic [LEN_W-1:0]      xfer_len_i,
  output logic [DATA_W-1:0]     dma_addr_o,
  output logic                  irq_o,
  output logic                  periph_rst_o,
  output logic                  periph_en_o,
  output logic                  mem_wr_dir_o
);
  localparam int SEL_LSB   = 2;
  localparam int SEL_W     = 2;
  localparam int N_PLAIN   = 2;
  localparam int PLAIN_OFS = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  reg_sel_e          sel;
  logic              wr_ok;
  logic [DATA_W-1:0] csr_q;
  logic [DATA_W-1:0] plain_q [N_PLAIN];
  logic              unused_addr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign sel   = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);
  assign wr_ok = bus_wr && (bus_be == 4'hF);
  assign unused_addr_bits = ^{bus_addr[BUS_ADDR_W-1:SEL_LSB+SEL_W], bus_addr[SEL_LSB-1:0]};

  dma_csr_ctl u_csr (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .wr_csr       (wr_ok && sel == SEL_CSR),
    .wdata        (bus_wdata),
    .loaded_set   (wr_ok && sel == SEL_ADDR),
    .irq_req      (irq_req_i),
    .csr_q        (csr_q),
    .irq_o        (irq_o),
    .periph_rst_o (periph_rst_o),
    .periph_en_o  (periph_en_o),
    .mem_wr_dir_o (mem_wr_dir_o)
  );

  dma_addr_cnt #(.LEN_W(LEN_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr        (wr_ok && sel == SEL_ADDR),
    .wdata     (bus_wdata),
    .xfer_done (xfer_done_i),
    .xfer_len  (xfer_len_i),
    .addr_q    (dma_addr_o)
  );

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    dma_word_reg u_word (
      .clk   (clk),
      .rst_n (rst_n_s),
      .wr    (wr_ok && (sel == reg_sel_e'(PLAIN_OFS + g))),
      .wdata (bus_wdata),
      .q     (plain_q[g])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_CSR:   bus_rdata = csr_q;
      SEL_ADDR:  bus_rdata = dma_addr_o;
      SEL_COUNT: bus_rdata = plain_q[0];
      default:   bus_rdata = plain_q[1];
    endcase
  end

  p_partial_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_wr && bus_be != 4'hF && !xfer_done_i) |=>
      ($stable(plain_q[0]) && $stable(plain_q[1]) && $stable(dma_addr_o) && $stable(periph_en_o)));
  p_irq_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq_o |-> $past(irq_req_i));
endmodule

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic        xfer_done;
  logic [15:0] xfer_len;
  logic [31:0] dma_addr;
  logic        irq_o, periph_rst, periph_en, mem_dir;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // behavioural reference state
  logic [31:0] m_reg [4];
  bit          m_pulse;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  dma_chan_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req_i(irq_req),
    .xfer_done_i(xfer_done), .xfer_len_i(xfer_len), .dma_addr_o(dma_addr),
    .irq_o(irq_o), .periph_rst_o(periph_rst), .periph_en_o(periph_en), .mem_wr_dir_o(mem_dir)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] = 32'hA000_0000;
      m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
      m_pulse  = 0;
    end else begin
      m_pulse = 0;
      if (xfer_done) m_reg[1] = m_reg[1] + {16'h0, xfer_len};
      if (bus_wr && bus_be == 4'hF) begin
        case (int'(bus_addr[3:2]))
          0: begin
            v = bus_wdata;
            if (v[7]) m_pulse = 1;
            else if (v[6]) v[6] = 0;
            else if (v == 0) v = 32'h40;
            m_reg[0] = (m_reg[0] & 32'hFE00_0007) | (v & 32'h01FF_FFF8) | 32'hA000_0000;
          end
          1: begin m_reg[1] = bus_wdata; m_reg[0][26] = 1; end
          default: m_reg[int'(bus_addr[3:2])] = bus_wdata;
        endcase
      end
      m_reg[0][0] = irq_req;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 irq", {31'b0, irq_o}, {31'b0, m_reg[0][0] & m_reg[0][4]});
      check("R6 rst pulse", {31'b0, periph_rst}, {31'b0, m_pulse});
      check("R9 enable", {31'b0, periph_en}, {31'b0, m_reg[0][9]});
      check("R9 direction", {31'b0, mem_dir}, {31'b0, m_reg[0][8]});
      check("R11 address", dma_addr, m_reg[1]);
      check("R2 rdata", bus_rdata, m_reg[int'(bus_addr[3:2])]);
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    #500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_addr = 0; bus_be = 4'hF; bus_wdata = 0;
    irq_req = 0; xfer_done = 0; xfer_len = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) step();
    // R1 reset state
    rd(6'h00, 32'hA000_0000, "R1 csr reset");
    rd(6'h04, 0, "R1 addr reset");
    rd(6'h08, 0, "R1 count reset");
    rd(6'h0C, 0, "R1 base reset");
    check("R1 outputs reset", {28'b0, irq_o, periph_rst, periph_en, mem_dir}, 0);
    // R12 plain words, R2 aliasing
    wr(6'h08, 32'h0000_1234);
    rd(6'h28, 32'h0000_1234, "R2 alias count");
    wr(6'h3C, 32'hDEAD_BEEF);
    rd(6'h0C, 32'hDEAD_BEEF, "R12 base store");
    // R3 partial writes
    wr(6'h08, 32'hFFFF_FFFF, 4'h3);
    rd(6'h08, 32'h0000_1234, "R3 partial count");
    wr(6'h00, 32'h0000_0200, 4'hE);
    check("R3 partial csr enable", {31'b0, periph_en}, 0);
    // R7 drain rules
    wr(6'h00, 32'h0);
    rd(6'h00, 32'hA000_0040, "R7 zero write");
    wr(6'h00, 32'h40);
    rd(6'h00, 32'hA000_0000, "R7 drain cleared");
    wr(6'h00, 32'hC0);
    check("R6 pulse high", {31'b0, periph_rst}, 1);
    rd(6'h00, 32'hA000_00C0, "R7 drain kept with reset");
    step();
    check("R6 pulse one cycle", {31'b0, periph_rst}, 0);
    // R8 read-only mask and version
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, 32'hA1FF_FFF8, "R8 ro mask");
    check("R9 enable on", {30'b0, periph_en, mem_dir}, 2'b11);
    wr(6'h00, 32'h0000_0010);
    check("R9 enable off", {31'b0, periph_en}, 0);
    // R4/R5 interrupt gating
    irq_req = 1; step();
    check("R5 irq raised", {31'b0, irq_o}, 1);
    rd(6'h00, 32'hA000_0011, "R4 pending set");
    wr(6'h00, 32'h0);
    check("R5 irq lowered by enable clear", {31'b0, irq_o}, 0);
    rd(6'h00, 32'hA000_0041, "R4 pending kept");
    wr(6'h20, 32'h10);
    check("R5 irq raised by enable set", {31'b0, irq_o}, 1);
    irq_req = 0; step();
    check("R4 irq dropped with request", {31'b0, irq_o}, 0);
    wr(6'h00, 32'h1);
    rd(6'h00, 32'hA000_0000, "R4 pending not writable");
    // R10 / R11 address
    wr(6'h04, 32'h0000_1000);
    rd(6'h00, 32'hA400_0000, "R10 loaded set");
    xfer_done = 1; xfer_len = 16'h20; step();
    xfer_len = 16'h3; step(); step();
    xfer_done = 0;
    check("R11 advance", dma_addr, 32'h0000_1026);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = 6'h04; bus_wdata = 32'h5000; xfer_done = 1; xfer_len = 8;
    step();
    bus_wr = 0; xfer_done = 0;
    check("R11 write wins", dma_addr, 32'h0000_5000);
    wr(6'h14, 32'hFFFF_FFF0);
    xfer_done = 1; xfer_len = 16'h20; step(); xfer_done = 0;
    check("R11 wrap", dma_addr, 32'h0000_0010);
    wr(6'h00, 32'h0);
    rd(6'h00, 32'hA400_0040, "R10 loaded sticky");
    // random phase, compared every clock
    for (int i = 0; i < 3000; i++) begin
      bus_wr    = $urandom_range(0, 2) == 0;
      bus_addr  = 6'($urandom);
      bus_be    = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      bus_wdata = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom;
      irq_req   = $urandom_range(0, 1) == 1;
      xfer_done = $urandom_range(0, 2) == 0;
      xfer_len  = 16'($urandom);
      step();
    end
    bus_wr = 0; xfer_done = 0;
    step();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule